// File: doc/BRIEF.md
# Hybrid delta-sigma pulse-width modulator

This block turns a wide duty command into a fixed-frequency pulse train for the switch of a buck converter. A free-running counter on the system clock sets the switching period. Each period starts with the output high. The pulse ends at a point given by a short duty word.

The short word comes from a second-order cascaded-accumulator delta-sigma stage. This stage drops the low bits of the command. It then dithers the remaining word by a few counts from one period to the next, so that the average over many periods keeps the full command resolution. The short word is split in two parts:

- The upper bits pick the clock cycle in which the pulse ends.
- The lower two bits pick which of four phase-shifted copies of the clock ends the pulse inside that cycle. The phase copies are 90 degrees apart, so each step is a quarter of a clock cycle.

A single-cycle strobe marks every period start, so that a control loop can sample in step with switching.

Top module: `hds_pwm`

## Requirements
- R1: The switching period is exactly 2^CNT_W system clock cycles (64 by default). `period_stb` is high for exactly one cycle at the start of each period.
- R2: The output rises at the start of the period. It stays high for `w` quarter-cycles, where `w` is the duty word in use for that period: `w>>2` whole cycles, then the part of a cycle given by phase `w[1:0]`.
- R3: After reset, a command whose low four bits are zero produces a word equal to `duty_cmd>>4` in every period, with no dither.
- R4: With the command held constant, the words of any 16 consecutive periods add up to `16*(duty_cmd>>4) + duty_cmd[3:0]`, within ±1.
- R5: A command of 0 keeps the output low for the whole period, whatever state the accumulators hold.
- R6: A command of all ones (4095) keeps the output high for the whole period. The word is then 256.
- R7: The command is sampled only at the period boundary. Changing it mid-period leaves the pulse in progress unchanged, and the new value takes effect in the next period.
- R8: While reset is asserted, the output and the strobe are low. After release, the output stays low until the first strobe.
- R9: The word is saturated to the range 0 to 256. Near the top of the range, each period holds between 254 and 256 quarter-cycles. Near zero, each period holds between 0 and 2 quarter-cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock. It also serves as phase 0. |
| rst_n | input | 1 | Asynchronous active-low reset. |
| clk_ph | input | 2^PH_W | Phase-shifted clocks. Bit k lags `clk` by k/2^PH_W of a cycle. Bit 0 is `clk` itself. |
| duty_cmd | input | DUTY_W | Duty command, full scale at all ones. |
| pwm_out | output | 1 | Drive signal for the switch. |
| period_stb | output | 1 | One-cycle strobe at the start of each period. |

## Verification
Each internal fault has a distinct signature at the ports:

- A corrupted period counter moves the next strobe away from its 64-cycle spacing. It is visible within one period.
- A wrong word register or a wrong coarse/fine split changes the measured high time of the very next period by a whole cycle or by a quarter-cycle.
- Faulty accumulators or carry combination may leave single periods plausible. They still shift the sum over 16 periods, so the bench measures high time at quarter-cycle resolution over such windows.

// File: rtl/hds_pkg.sv
package hds_pkg;
  parameter int DEF_DUTY_W = 12;
  parameter int DEF_CNT_W  = 6;
  parameter int DEF_PH_W   = 2;
endpackage

// File: rtl/hds_mash.sv
module hds_mash #(
  parameter int DUTY_W = hds_pkg::DEF_DUTY_W,
  parameter int M      = 8,
  localparam int FR_W   = DUTY_W - M,
  localparam int WORD_W = M + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic [DUTY_W-1:0] cmd,
  output logic [WORD_W-1:0] word_next
);
  localparam logic [WORD_W-1:0] FULL = WORD_W'(1) << M;

  logic [FR_W-1:0] acc1_q, acc2_q;
  logic            c2d_q;
  logic [FR_W:0]   s1, s2;
  logic            carry1, carry2;

  // combine truncated word with the two carries, clamp to [0, FULL]
  function automatic logic [WORD_W-1:0] ds_word(
      input logic [M-1:0] tr, input logic a, input logic b, input logic bd);
    logic [WORD_W:0] s;
    s = {2'b00, tr} + {{WORD_W{1'b0}}, a} + {{WORD_W{1'b0}}, b};
    if (s < {{WORD_W{1'b0}}, bd}) return '0;
    s = s - {{WORD_W{1'b0}}, bd};
    if (s > {1'b0, FULL}) return FULL;
    return s[WORD_W-1:0];
  endfunction

  always_comb begin
    s1     = {1'b0, acc1_q} + {1'b0, cmd[FR_W-1:0]};
    carry1 = s1[FR_W];
    s2     = {1'b0, acc2_q} + {1'b0, s1[FR_W-1:0]};
    carry2 = s2[FR_W];
    if (cmd == '0)
      word_next = '0;
    else if (&cmd)
      word_next = FULL;
    else
      word_next = ds_word(cmd[DUTY_W-1:FR_W], carry1, carry2, c2d_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc1_q <= '0;
      acc2_q <= '0;
      c2d_q  <= 1'b0;
    end else if (step) begin
      acc1_q <= s1[FR_W-1:0];
      acc2_q <= s2[FR_W-1:0];
      c2d_q  <= carry2;
    end
  end
endmodule

// File: rtl/hds_phase_win.sv
module hds_phase_win #(
  parameter int PH_W = hds_pkg::DEF_PH_W,
  localparam int NPH = 2 ** PH_W
) (
  input  logic [NPH-1:0]  ph,
  input  logic [PH_W-1:0] sel,
  output logic            win
);
  // slot j is high between the rising edges of phase j and phase j+1
  logic [NPH-2:0] term;
  for (genvar j = 0; j < NPH - 1; j++) begin : g_slot
    assign term[j] = ph[j] & ~ph[j+1] & (sel > PH_W'(j));
  end
  assign win = |term;
endmodule

// File: rtl/hds_pwm.sv
module hds_pwm #(
  parameter int DUTY_W = hds_pkg::DEF_DUTY_W,
  parameter int CNT_W  = hds_pkg::DEF_CNT_W,
  parameter int PH_W   = hds_pkg::DEF_PH_W,
  localparam int NPH    = 2 ** PH_W,
  localparam int M      = CNT_W + PH_W,
  localparam int WORD_W = M + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NPH-1:0]    clk_ph,
  input  logic [DUTY_W-1:0] duty_cmd,
  output logic              pwm_out,
  output logic              period_stb
);
  localparam logic [CNT_W-1:0] CMAX = '1;

  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic              wrap;
  logic [WORD_W-1:0] word_n, word_q, eff_word;
  logic [CNT_W:0]    coarse;
  logic [PH_W-1:0]   fine, fine_q;
  logic              hi_q, ext_q, stb_q, win;

  assign wrap  = (cnt_q == CMAX);
  assign cnt_n = wrap ? '0 : cnt_q + 1'b1;

  hds_mash #(.DUTY_W(DUTY_W), .M(M)) u_mash (
    .clk(clk), .rst_n(rst_n), .step(wrap), .cmd(duty_cmd), .word_next(word_n)
  );

  assign eff_word = wrap ? word_n : word_q;
  assign coarse   = eff_word[WORD_W-1:PH_W];
  assign fine     = eff_word[PH_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      word_q <= '0;
      hi_q   <= 1'b0;
      ext_q  <= 1'b0;
      fine_q <= '0;
      stb_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_n;
      if (wrap) word_q <= word_n;
      hi_q   <= ({1'b0, cnt_n} < coarse);
      ext_q  <= ({1'b0, cnt_n} == coarse) && (fine != '0);
      fine_q <= fine;
      stb_q  <= wrap;
    end
  end

  hds_phase_win #(.PH_W(PH_W)) u_win (.ph(clk_ph), .sel(fine_q), .win(win));

  assign pwm_out    = hi_q | (ext_q & win);
  assign period_stb = stb_q;
endmodule

// File: rtl/hds_pwm_chk.sv
module hds_pwm_chk #(
  parameter int DUTY_W = 12,
  parameter int CNT_W  = 6,
  parameter int WORD_W = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wrap,
  input logic              period_stb,
  input logic [WORD_W-1:0] word_q,
  input logic              hi_q,
  input logic              ext_q,
  input logic [DUTY_W-1:0] duty_cmd
);
  localparam logic [WORD_W-1:0] FULL = WORD_W'(1) << (WORD_W - 1);
  localparam logic [CNT_W:0]    PER  = (CNT_W+1)'(1) << CNT_W;

  logic [CNT_W:0] cyc_q;
  logic           seen_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_q  <= '0;
      seen_q <= 1'b0;
    end else begin
      cyc_q  <= period_stb ? (CNT_W+1)'(1) : cyc_q + 1'b1;
      seen_q <= seen_q | wrap;
    end
  end

  // R1
  period_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    period_stb |-> cyc_q == PER);
  // R1
  strobe_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    period_stb |=> !period_stb);
  // R1
  strobe_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> period_stb);
  // R7
  word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> $stable(word_q));
  // R9
  word_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_q <= FULL);
  // R8
  first_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !seen_q |-> !(hi_q || ext_q));
  // R5
  zero_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && duty_cmd == '0) |=> word_q == '0);
  // R6
  full_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && &duty_cmd) |=> word_q == FULL);
endmodule

bind hds_pwm hds_pwm_chk #(.DUTY_W(DUTY_W), .CNT_W(CNT_W), .WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wrap(wrap), .period_stb(period_stb),
  .word_q(word_q), .hi_q(hi_q), .ext_q(ext_q), .duty_cmd(duty_cmd)
);

// File: tb/hds_pwm_tb.sv
`timescale 1ns/1ps
module hds_pwm_tb;
  logic clk = 1'b0, ph1 = 1'b0, ph2 = 1'b0, ph3 = 1'b0;
  logic rst_n = 1'b0;
  logic [11:0] cmd = '0;
  logic pwm, stb;
  logic [3:0] ph;
  int checks = 0, fails = 0;
  int hi_cnt = 0, cyc_cnt = 0;

  assign ph = {ph3, ph2, ph1, clk};

  initial forever #4 clk = ~clk;
  initial begin #2; forever #4 ph1 = ~ph1; end
  initial begin #4; forever #4 ph2 = ~ph2; end
  initial begin #6; forever #4 ph3 = ~ph3; end

  // one sample per ns, offset half a ns from every edge: samples = 2 per quarter-cycle
  initial begin #0.5; forever begin if (pwm) hi_cnt++; #1; end end
  always @(negedge clk) cyc_cnt++;

  hds_pwm u_dut (.clk(clk), .rst_n(rst_n), .clk_ph(ph), .duty_cmd(cmd),
                 .pwm_out(pwm), .period_stb(stb));

  localparam logic [11:0] VEC [9] = '{12'h000, 12'hFFF, 12'h100, 12'h7F0, 12'h2A0,
                                      12'h805, 12'h3C8, 12'hA5F, 12'h011};

  task automatic chk(string tag, int got, int exp);
    checks++;
    if (got != exp) begin fails++; $display("FAIL %s got=%0d expected=%0d", tag, got, exp); end
  endtask

  task automatic chk_rng(string tag, int got, int lo, int hi);
    checks++;
    if (got < lo || got > hi) begin
      fails++; $display("FAIL %s got=%0d expected=%0d..%0d", tag, got, lo, hi);
    end
  endtask

  task automatic meas(output int hi, output int cyc);
    hi_cnt = 0; cyc_cnt = 0;
    @(posedge stb);
    hi = hi_cnt; cyc = cyc_cnt;
  endtask

  task automatic do_reset(input logic [11:0] c);
    int h, y;
    @(negedge clk); rst_n = 1'b0; cmd = c;
    repeat (3) @(posedge clk);
    #1;
    chk("R8 reset pwm", int'(pwm), 0);
    chk("R8 reset strobe", int'(stb), 0);
    @(negedge clk); rst_n = 1'b1;
    meas(h, y);
    chk("R8 low until first strobe", h, 0);
  endtask

  initial begin
    int h, y, sum, tr, fr;
    for (int v = 0; v < 9; v++) begin
      do_reset(VEC[v]);
      tr = int'(VEC[v] >> 4); fr = int'(VEC[v] & 12'hF);
      sum = 0;
      for (int p = 0; p < 16; p++) begin
        meas(h, y);
        chk("R1 period cycles", y, 64);
        sum += h / 2;
        if (VEC[v] == 12'h000) chk("R5 zero duty", h, 0);
        else if (VEC[v] == 12'hFFF) chk("R6 full duty", h, 512);
        else if (fr == 0) chk("R2 R3 exact width", h, 2 * tr);
      end
      if (tr >= 1 && tr <= 253) chk_rng("R4 16-period sum", sum, 16 * tr + fr - 1, 16 * tr + fr + 1);
    end

    // R1 strobe is exactly one cycle wide
    @(posedge stb); @(negedge clk);
    chk("R1 strobe high", int'(stb), 1);
    @(negedge clk);
    chk("R1 strobe drops", int'(stb), 0);

    // R9 saturation near top and bottom
    do_reset(12'hFFE);
    for (int p = 0; p < 16; p++) begin meas(h, y); chk_rng("R9 top range", h / 2, 254, 256); end
    do_reset(12'h001);
    for (int p = 0; p < 16; p++) begin meas(h, y); chk_rng("R9 bottom range", h / 2, 0, 2); end

    // R5 zero command after dithering state was left in the accumulators
    @(negedge clk); cmd = 12'h000;
    @(posedge stb);
    for (int p = 0; p < 4; p++) begin meas(h, y); chk("R5 zero after dither", h, 0); end

    // R7 mid-period change does not touch the running pulse
    do_reset(12'h200);
    hi_cnt = 0; cyc_cnt = 0;
    repeat (10) @(negedge clk);
    cmd = 12'h500;
    @(posedge stb);
    chk("R7 pulse in progress kept", hi_cnt, 64);
    meas(h, y);
    chk("R7 new command next period", h, 160);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 8);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule